// File: doc/BRIEF.md
# ADC Calibration Sequencer and Done Flag

This block holds the calibration control and the register file of a delta-sigma converter. The modulator and digital filter are not part of it. They appear at the boundary as a one-cycle `conv_done` strobe and a 24-bit `conv_result` word. A host writes a 3-bit calibration command into the low bits of the configuration register. The block then steers the next one or two conversion results into the offset register or the gain register. When the run ends, it returns the command bits to 000 and raises a done flag.

The same done flag also reports ordinary conversions that land in the data register. It is cleared as a side effect of reading the data, offset, gain or setup register. Reading the configuration register does not clear it, so a host can poll the command bits without losing the event.

The sequencer has three states:
- `ST_IDLE`: no calibration runs, and conversions go to the data register.
- `ST_OFS`: the offset step.
- `ST_GAIN`: the gain step.

The transitions are:
- `ST_IDLE`→`ST_OFS` on a configuration write with code 001 or 011.
- `ST_IDLE`→`ST_GAIN` on code 010.
- `ST_OFS`→`ST_GAIN` on `conv_done` when the combined code 011 is active.
- `ST_OFS`→`ST_IDLE` on `conv_done` otherwise.
- `ST_GAIN`→`ST_IDLE` on `conv_done`.

The register addresses are 0 data (read-only), 1 offset, 2 gain, 3 setup and 4 configuration. Addresses 5 to 7 read as zero. Read data is combinational from the current register contents.

Top module: `adc_cal_ctrl`

## Requirements
- R1: After reset the offset, data, setup and configuration registers read 0. The gain register reads 0x800000 (MSB set, all other bits clear). `done_flag` and `cal_busy` are 0.
- R2: Writing command code 001 into configuration bits [2:0] sets `cal_busy`. The next `conv_done` result is written into the offset register and completes the calibration.
- R3: Command code 010 writes the next `conv_done` result into the gain register and completes the calibration after that one conversion.
- R4: Command code 011 writes the first result into the offset register and the second into the gain register. `done_flag` stays 0 and `cal_busy` stays 1 between the two steps.
- R5: When a calibration completes, configuration bits [2:0] read 000 in the following cycle.
- R6: `done_flag` becomes 1 in the cycle after a calibration completes. It also becomes 1 in the cycle after a `conv_done` while idle.
- R7: A read of address 0, 1, 2 or 3 clears `done_flag` in the following cycle. If a set event happens in the same cycle, the set wins.
- R8: A read of address 4 (configuration) leaves `done_flag` unchanged.
- R9: A configuration write whose bits [2:0] are 100 to 111 starts nothing and leaves bits [2:0] at their value. Bits [23:3] are still written.
- R10: While `cal_busy` is 1, conversion results do not change the data register.
- R11: A configuration write during a calibration does not change bits [2:0] or the running sequence.
- R12: Writes to address 0 are ignored. Setup at address 3 reads back what was written. Addresses 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (drives the done-flag side effect) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 24 | Write data |
| reg_rdata | output | 24 | Read data for `reg_addr`, combinational |
| conv_done | input | 1 | One-cycle strobe: a conversion result is ready |
| conv_result | input | 24 | Conversion result word |
| done_flag | output | 1 | Done flag |
| cal_busy | output | 1 | A calibration step is in progress |

## Verification
The assertions assume these input rules:
- `conv_done` is a single-cycle pulse.
- `reg_rd` and `reg_wr` are never raised together.
- Reset is synchronous and held for at least one clock edge.

The stimulus drives each operation for exactly one cycle on the falling edge and keeps read and write strobes in separate cycles. One directed case deliberately places a read that clears the flag in the same cycle as a conversion strobe, to cover the rule that the set wins.

// File: rtl/adc_cal_pkg.sv
package adc_cal_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_OFS  = 2'd1,
        ST_GAIN = 2'd2
    } cal_state_e;

    localparam int CMD_W = 3;

    localparam logic [CMD_W-1:0] CMD_NONE = 3'b000;
    localparam logic [CMD_W-1:0] CMD_OFS  = 3'b001;
    localparam logic [CMD_W-1:0] CMD_GAIN = 3'b010;
    localparam logic [CMD_W-1:0] CMD_BOTH = 3'b011;

    localparam logic [2:0] ADDR_DATA = 3'd0;
    localparam logic [2:0] ADDR_OFS  = 3'd1;
    localparam logic [2:0] ADDR_GAIN = 3'd2;
    localparam logic [2:0] ADDR_SET  = 3'd3;
    localparam logic [2:0] ADDR_CFG  = 3'd4;

endpackage

// File: rtl/adc_cal_fsm.sv
module adc_cal_fsm
    import adc_cal_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic [CMD_W-1:0] cmd_wdata,
    input  logic             conv_done,
    output logic [CMD_W-1:0] cmd_bits,
    output logic             cal_busy,
    output logic             ofs_capture,
    output logic             gain_capture,
    output logic             cal_finish
);

    cal_state_e       state_q, state_d;
    logic [CMD_W-1:0] cmd_q, cmd_d;
    logic             both_q, both_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        cmd_d   = cmd_q;
        both_d  = both_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_wr) begin
                    if (cmd_wdata == CMD_OFS || cmd_wdata == CMD_BOTH) begin
                        state_d = ST_OFS;
                        cmd_d   = cmd_wdata;
                        both_d  = (cmd_wdata == CMD_BOTH);
                    end else if (cmd_wdata == CMD_GAIN) begin
                        state_d = ST_GAIN;
                        cmd_d   = cmd_wdata;
                        both_d  = 1'b0;
                    end
                end
            end
            ST_OFS: begin
                if (conv_done) begin
                    if (both_q) begin
                        state_d = ST_GAIN;
                    end else begin
                        state_d = ST_IDLE;
                        cmd_d   = CMD_NONE;
                    end
                end
            end
            ST_GAIN: begin
                if (conv_done) begin
                    state_d = ST_IDLE;
                    cmd_d   = CMD_NONE;
                    both_d  = 1'b0;
                end
            end
            default: begin
                state_d = ST_IDLE;
                cmd_d   = CMD_NONE;
                both_d  = 1'b0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cmd_q   <= CMD_NONE;
            both_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cmd_q   <= cmd_d;
            both_q  <= both_d;
        end
    end

    // outputs
    always_comb begin
        cmd_bits     = cmd_q;
        cal_busy     = (state_q != ST_IDLE);
        ofs_capture  = (state_q == ST_OFS)  && conv_done;
        gain_capture = (state_q == ST_GAIN) && conv_done;
        cal_finish   = (ofs_capture && !both_q) || gain_capture;
    end

    // R5
    finish_clears_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_finish |=> (cmd_bits == CMD_NONE && !cal_busy));

    // R4
    combo_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ofs_capture && both_q) |=> (state_q == ST_GAIN && cal_busy));

    // R11
    busy_cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_busy && !conv_done) |=> $stable(cmd_bits));

endmodule

// File: rtl/adc_cal_regs.sv
module adc_cal_regs
    import adc_cal_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [2:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_result,
    input  logic              cal_busy,
    input  logic              ofs_capture,
    input  logic              gain_capture,
    input  logic              cal_finish,
    input  logic [CMD_W-1:0]  cmd_bits,
    output logic [DATA_W-1:0] rdata,
    output logic              done_flag
);

    localparam int                HI_W     = DATA_W - CMD_W;
    localparam logic [DATA_W-1:0] GAIN_RST = {1'b1, {(DATA_W-1){1'b0}}};

    logic [DATA_W-1:0] data_q, ofs_q, gain_q, set_q;
    logic [HI_W-1:0]   cfg_hi_q;
    logic              done_q;
    logic              flag_set, flag_clr, clr_addr;

    assign clr_addr = (addr == ADDR_DATA) || (addr == ADDR_OFS) ||
                      (addr == ADDR_GAIN) || (addr == ADDR_SET);
    assign flag_set = cal_finish || (conv_done && !cal_busy);
    assign flag_clr = rd_en && clr_addr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q   <= '0;
            ofs_q    <= '0;
            gain_q   <= GAIN_RST;
            set_q    <= '0;
            cfg_hi_q <= '0;
            done_q   <= 1'b0;
        end else begin
            if (conv_done && !cal_busy)
                data_q <= conv_result;
            if (ofs_capture)
                ofs_q <= conv_result;
            else if (wr_en && addr == ADDR_OFS)
                ofs_q <= wdata;
            if (gain_capture)
                gain_q <= conv_result;
            else if (wr_en && addr == ADDR_GAIN)
                gain_q <= wdata;
            if (wr_en && addr == ADDR_SET)
                set_q <= wdata;
            if (wr_en && addr == ADDR_CFG)
                cfg_hi_q <= wdata[DATA_W-1:CMD_W];
            if (flag_set)
                done_q <= 1'b1;
            else if (flag_clr)
                done_q <= 1'b0;
        end
    end

    always_comb begin
        unique case (addr)
            ADDR_DATA: rdata = data_q;
            ADDR_OFS:  rdata = ofs_q;
            ADDR_GAIN: rdata = gain_q;
            ADDR_SET:  rdata = set_q;
            ADDR_CFG:  rdata = {cfg_hi_q, cmd_bits};
            default:   rdata = '0;
        endcase
    end

    assign done_flag = done_q;

    // R6
    done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_finish || (conv_done && !cal_busy)) |=> done_flag);

    // R8
    cfg_read_keeps_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_CFG && !cal_finish && !(conv_done && !cal_busy))
        |=> $stable(done_flag));

    // R7
    read_clears_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr <= ADDR_SET && !cal_finish && !(conv_done && !cal_busy))
        |=> !done_flag);

    // R10
    busy_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_busy |=> $stable(data_q));

endmodule

// File: rtl/adc_cal_ctrl.sv
module adc_cal_ctrl
    import adc_cal_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [2:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_result,
    output logic              done_flag,
    output logic              cal_busy
);

    logic             cfg_wr;
    logic [CMD_W-1:0] cmd_bits;
    logic             ofs_capture, gain_capture, cal_finish;

    assign cfg_wr = reg_wr && (reg_addr == ADDR_CFG);

    adc_cal_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_wr      (cfg_wr),
        .cmd_wdata   (reg_wdata[CMD_W-1:0]),
        .conv_done   (conv_done),
        .cmd_bits    (cmd_bits),
        .cal_busy    (cal_busy),
        .ofs_capture (ofs_capture),
        .gain_capture(gain_capture),
        .cal_finish  (cal_finish)
    );

    adc_cal_regs #(.DATA_W(DATA_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (reg_wr),
        .rd_en       (reg_rd),
        .addr        (reg_addr),
        .wdata       (reg_wdata),
        .conv_done   (conv_done),
        .conv_result (conv_result),
        .cal_busy    (cal_busy),
        .ofs_capture (ofs_capture),
        .gain_capture(gain_capture),
        .cal_finish  (cal_finish),
        .cmd_bits    (cmd_bits),
        .rdata       (reg_rdata),
        .done_flag   (done_flag)
    );

endmodule

// File: tb/adc_cal_ctrl_test.sv
`timescale 1ns/1ps
module adc_cal_ctrl_test;

    localparam logic [1:0] OP_WR = 2'd0;
    localparam logic [1:0] OP_RD = 2'd1;
    localparam logic [1:0] OP_CV = 2'd2;
    localparam logic [1:0] OP_DN = 2'd3;

    typedef struct packed {
        logic [1:0]  op;
        logic [2:0]  addr;
        logic [23:0] data;
        logic [23:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 41;
    // OP_DN expect: bit0 = done_flag, bit1 = cal_busy
    localparam vec_t VECS [NV] = '{
        '{OP_DN, 3'd0, 24'h0,      24'h000000, 4'd1},  // R1
        '{OP_RD, 3'd2, 24'h0,      24'h800000, 4'd1},  // R1
        '{OP_RD, 3'd1, 24'h0,      24'h000000, 4'd1},  // R1
        '{OP_RD, 3'd4, 24'h0,      24'h000000, 4'd1},  // R1
        '{OP_CV, 3'd0, 24'h123456, 24'h000000, 4'd6},  // R6
        '{OP_DN, 3'd0, 24'h0,      24'h000001, 4'd6},  // R6
        '{OP_RD, 3'd4, 24'h0,      24'h000000, 4'd8},  // R8
        '{OP_DN, 3'd0, 24'h0,      24'h000001, 4'd8},  // R8
        '{OP_RD, 3'd0, 24'h0,      24'h123456, 4'd7},  // R7
        '{OP_DN, 3'd0, 24'h0,      24'h000000, 4'd7},  // R7
        '{OP_WR, 3'd4, 24'h000001, 24'h000000, 4'd2},  // R2
        '{OP_DN, 3'd0, 24'h0,      24'h000002, 4'd2},  // R2
        '{OP_RD, 3'd4, 24'h0,      24'h000001, 4'd2},  // R2
        '{OP_WR, 3'd4, 24'h000002, 24'h000000, 4'd11}, // R11
        '{OP_RD, 3'd4, 24'h0,      24'h000001, 4'd11}, // R11
        '{OP_CV, 3'd0, 24'h0000AA, 24'h000000, 4'd2},  // R2
        '{OP_DN, 3'd0, 24'h0,      24'h000001, 4'd6},  // R6
        '{OP_RD, 3'd4, 24'h0,      24'h000000, 4'd5},  // R5
        '{OP_RD, 3'd1, 24'h0,      24'h0000AA, 4'd2},  // R2
        '{OP_RD, 3'd0, 24'h0,      24'h123456, 4'd10}, // R10
        '{OP_DN, 3'd0, 24'h0,      24'h000000, 4'd7},  // R7
        '{OP_WR, 3'd4, 24'h000002, 24'h000000, 4'd3},  // R3
        '{OP_CV, 3'd0, 24'h400100, 24'h000000, 4'd3},  // R3
        '{OP_RD, 3'd2, 24'h0,      24'h400100, 4'd3},  // R3
        '{OP_DN, 3'd0, 24'h0,      24'h000000, 4'd7},  // R7
        '{OP_WR, 3'd4, 24'h000003, 24'h000000, 4'd4},  // R4
        '{OP_CV, 3'd0, 24'h000011, 24'h000000, 4'd4},  // R4
        '{OP_DN, 3'd0, 24'h0,      24'h000002, 4'd4},  // R4
        '{OP_RD, 3'd1, 24'h0,      24'h000011, 4'd4},  // R4
        '{OP_CV, 3'd0, 24'h7FFFFF, 24'h000000, 4'd4},  // R4
        '{OP_DN, 3'd0, 24'h0,      24'h000001, 4'd4},  // R4
        '{OP_RD, 3'd2, 24'h0,      24'h7FFFFF, 4'd4},  // R4
        '{OP_RD, 3'd4, 24'h0,      24'h000000, 4'd5},  // R5
        '{OP_WR, 3'd4, 24'h0000F5, 24'h000000, 4'd9},  // R9
        '{OP_DN, 3'd0, 24'h0,      24'h000000, 4'd9},  // R9
        '{OP_RD, 3'd4, 24'h0,      24'h0000F0, 4'd9},  // R9
        '{OP_WR, 3'd3, 24'h00ABCD, 24'h000000, 4'd12}, // R12
        '{OP_RD, 3'd3, 24'h0,      24'h00ABCD, 4'd12}, // R12
        '{OP_WR, 3'd0, 24'h555555, 24'h000000, 4'd12}, // R12
        '{OP_RD, 3'd0, 24'h0,      24'h123456, 4'd12}, // R12
        '{OP_RD, 3'd6, 24'h0,      24'h000000, 4'd12}  // R12
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [23:0] reg_wdata = '0;
    logic [23:0] reg_rdata;
    logic        conv_done = 1'b0;
    logic [23:0] conv_result = '0;
    logic        done_flag;
    logic        cal_busy;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    adc_cal_ctrl uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .conv_done  (conv_done),
        .conv_result(conv_result),
        .done_flag  (done_flag),
        .cal_busy   (cal_busy)
    );

    task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        reg_wr    = 1'b0;
        reg_rd    = 1'b0;
        conv_done = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            idle_inputs();
            reg_addr = VECS[i].addr;
            unique case (VECS[i].op)
                OP_WR: begin reg_wr = 1'b1; reg_wdata = VECS[i].data; end
                OP_RD: reg_rd = 1'b1;
                OP_CV: begin conv_done = 1'b1; conv_result = VECS[i].data; end
                default: ;
            endcase
            #1;
            if (VECS[i].op == OP_RD)
                check($sformatf("R%0d rdata vec %0d", VECS[i].req, i), reg_rdata, VECS[i].exp);
            else if (VECS[i].op == OP_DN)
                check($sformatf("R%0d done/busy vec %0d", VECS[i].req, i),
                      {22'd0, cal_busy, done_flag}, VECS[i].exp);
        end

        // R7: read clearing the flag collides with a conversion; set wins
        @(negedge clk);
        idle_inputs();
        reg_rd = 1'b1; reg_addr = 3'd0;
        conv_done = 1'b1; conv_result = 24'h000777;
        @(negedge clk);
        idle_inputs();
        #1;
        check("R7 set wins over read clear", {23'd0, done_flag}, 24'd1);
        reg_rd = 1'b1; reg_addr = 3'd0;
        #1;
        check("R6 idle conversion lands in data", reg_rdata, 24'h000777);

        // R1: reset in the middle of a calibration
        @(negedge clk);
        idle_inputs();
        reg_wr = 1'b1; reg_addr = 3'd4; reg_wdata = 24'h000002;
        @(negedge clk);
        idle_inputs();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 busy after reset", {23'd0, cal_busy}, 24'd0);
        reg_addr = 3'd4;
        #1;
        check("R1 config after reset", reg_rdata, 24'd0);
        reg_addr = 3'd2;
        #1;
        check("R1 gain after reset", reg_rdata, 24'h800000);

        @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule